// File: doc/BRIEF.md
# Display Control Register Bus Slave

This block is the serial control port of a display control chip. A host addresses it over three wires: an active-low frame enable, a serial clock and one data line. Each frame has two halves. In the first half the host shifts in a 16-bit command word that carries a chip identifier, a register index and a 7-bit value. In the second half the block turns the data line around and shifts out a 16-bit reply word. The reply holds an acknowledge code, four status flags and an 8-bit tuning-error measurement.

Behind the port sit 32 seven-bit control registers, and the chip's power switch is bit 0 of register 0. Two sticky fault flags are kept as well: one for a sag of the standby supply and one for an over-voltage protection trip. Together with the power switch, these flags gate the PWM regulator enable and the horizontal drive enable. To recover from a fault, the host must switch the chip off and then on again. The serial inputs are oversampled in the system clock domain. The data line is split into a value pin and a drive-enable pin, so the chip pad can build the bidirectional line from them.

Top module: `ctl_bus_slave`

## Requirements
- R1: After reset, `pwm_en`, `hdrv_en` and `ser_doe` are low, all registers read zero on `ctl_regs`, and the supply-loss flag is set, so the first reply shows S0 = 1.
- R2: The command word is sent MSB first: bits 15..12 are the chip identifier, bits 11..7 the register index and bits 6..0 the value. When the identifier equals `CHIP_ID`, the value is written into the indexed register as the 16th bit is taken. Register n appears on `ctl_regs[7n+6:7n]`.
- R3: For a matching identifier, `ser_doe` is high for all 16 reply bits, and reply bits 15..12 carry the code 4'b1010.
- R4: For a non-matching identifier, `ser_doe` stays low throughout the reply half and no register changes.
- R5: Reply bits 11, 10, 9 and 8 carry S0 (supply-loss flag), S1 (protection flag), S2 (`hlock`) and S3 (`xfer_done`). Their values are taken when the 16th command bit is captured, before that command has any effect.
- R6: Reply bits 7..0 carry `tune_err`, MSB first, taken at the same moment as the status flags.
- R7: While the chip is on, a pulse on `stby_low` sets the supply-loss flag and the flag stays set. Writing ON again while already on does not clear it. It clears only when the power bit goes from 0 to 1.
- R8: If `stby_low` is still asserted when the power bit goes from 0 to 1, the supply-loss flag stays set and the drives stay off. They stay off even after `stby_low` is released.
- R9: While on, a pulse on `ovp_trip` sets the protection flag. The flag clears when the power bit goes from 1 to 0. While the power bit is 0, `ovp_trip` is ignored.
- R10: If the enable rises before all 16 command bits have arrived, the partial command is dropped, no register changes, and the next frame decodes normally.
- R11: `pwm_en` and `hdrv_en` are equal. They are high exactly when the power bit is 1 and neither fault flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bus clock; bits are taken on its rising edge |
| ser_en_n | input | 1 | Active-low frame enable |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial reply data |
| ser_doe | output | 1 | High while the block drives the data line |
| stby_low | input | 1 | Standby supply below threshold |
| ovp_trip | input | 1 | Over-voltage detector output |
| hlock | input | 1 | Horizontal lock indication |
| xfer_done | input | 1 | Delayed-transfer-complete indication |
| tune_err | input | 8 | Tuning-error measurement byte |
| pwm_en | output | 1 | PWM regulator enable |
| hdrv_en | output | 1 | Horizontal drive enable |
| ctl_regs | output | 224 | All control registers, register n at bits 7n+6..7n |

## Verification
A serial clock edge passes through two synchronizer stages and an edge detector, so the engine acts on it about three system cycles after the pin changes. The register write, and each new reply bit, follow one cycle after that. A fault input lowers the drives two cycles after it asserts. The bench holds each serial clock half for six system cycles. It reads the reply bit at the end of each low half, well past those latencies. Register contents and drive enables are checked at least six cycles after the stimulus that should have changed them.

// File: rtl/ctl_bus_pkg.sv
package ctl_bus_pkg;
  localparam int ADDR_W  = 4;
  localparam int SUB_W   = 5;
  localparam int VAL_W   = 7;
  localparam int WR_BITS = ADDR_W + SUB_W + VAL_W;
  localparam int ACK_W   = 4;
  localparam int STAT_W  = 4;
  localparam int MEAS_W  = 8;
  localparam int RD_BITS = ACK_W + STAT_W + MEAS_W;
  localparam int CNT_W   = $clog2(WR_BITS) + 1;
  localparam logic [ACK_W-1:0] ACK_CODE = 4'b1010;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_WAIT
  } bus_state_t;

  typedef struct packed {
    logic [SUB_W-1:0] sub;
    logic [VAL_W-1:0] val;
  } reg_wr_t;

  // field order is the reply order: S0 first
  typedef struct packed {
    logic por;
    logic ovp;
    logic lock;
    logic xfer;
  } status_t;
endpackage

// File: rtl/ctl_bus_sync.sv
module ctl_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_en_n,
  input  logic ser_din,
  output logic clk_rise,
  output logic en_n_s,
  output logic din_s
);
  logic [STAGES-1:0] clk_pipe;
  logic [STAGES-1:0] en_pipe;
  logic [STAGES-1:0] din_pipe;
  logic              clk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      en_pipe  <= '1;
      din_pipe <= '0;
      clk_last <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-2:0], ser_clk};
      en_pipe  <= {en_pipe[STAGES-2:0], ser_en_n};
      din_pipe <= {din_pipe[STAGES-2:0], ser_din};
      clk_last <= clk_pipe[STAGES-1];
    end
  end

  assign clk_rise = clk_pipe[STAGES-1] & ~clk_last;
  assign en_n_s   = en_pipe[STAGES-1];
  assign din_s    = din_pipe[STAGES-1];

  // R2: one bit taken per serial edge
  p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rise |=> !clk_rise);
endmodule

// File: rtl/ctl_bus_engine.sv
module ctl_bus_engine
  import ctl_bus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CHIP_ID = 4'h5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_rise,
  input  logic              en_n_s,
  input  logic              din_s,
  input  status_t           stat_in,
  input  logic [MEAS_W-1:0] meas_in,
  output logic              wr_valid,
  output reg_wr_t           wr_data,
  output logic              dout,
  output logic              doe
);
  bus_state_t          state;
  logic [CNT_W-1:0]    cnt;
  logic [WR_BITS-2:0]  wr_sr;
  logic [RD_BITS-1:0]  rd_sr;
  logic [WR_BITS-1:0]  word;

  assign word = {wr_sr, din_s};
  assign dout = rd_sr[RD_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      wr_sr    <= '0;
      rd_sr    <= '0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      doe      <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (en_n_s) begin
        state <= ST_IDLE;
        cnt   <= '0;
        doe   <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            state <= ST_WRITE;
            cnt   <= '0;
          end
          ST_WRITE: begin
            if (clk_rise) begin
              wr_sr <= word[WR_BITS-2:0];
              if (cnt == CNT_W'(WR_BITS - 1)) begin
                cnt   <= '0;
                state <= ST_READ;
                if (word[WR_BITS-1 -: ADDR_W] == CHIP_ID) begin
                  wr_valid <= 1'b1;
                  wr_data  <= reg_wr_t'(word[SUB_W+VAL_W-1:0]);
                  rd_sr    <= {ACK_CODE, stat_in, meas_in};
                  doe      <= 1'b1;
                end else begin
                  doe <= 1'b0;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_READ: begin
            if (clk_rise) begin
              rd_sr <= {rd_sr[RD_BITS-2:0], 1'b0};
              if (cnt == CNT_W'(RD_BITS - 1)) begin
                state <= ST_WAIT;
                doe   <= 1'b0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: the line is driven only in the reply half
  p_doe_in_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> state == ST_READ);
  // R2: a commit happens only at the start of the reply half
  p_commit_at_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (state == ST_READ && cnt == '0));
  // R10: a raised enable returns the engine to idle
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_s |=> state == ST_IDLE);
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctl_bus_pkg::*;
#(
  parameter int N_REGS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  input  reg_wr_t                 wr_data,
  output logic [N_REGS*VAL_W-1:0] regs_flat,
  output logic                    on_bit
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic [VAL_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r_q <= '0;
      else if (wr_valid && wr_data.sub == SUB_W'(g))
        r_q <= wr_data.val;
    end
    assign regs_flat[g*VAL_W +: VAL_W] = r_q;
  end

  assign on_bit = regs_flat[0];

  // R4: nothing changes without a committed write
  p_hold_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(regs_flat));
endmodule

// File: rtl/ctl_fault_guard.sv
module ctl_fault_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic on_bit,
  input  logic stby_low,
  input  logic ovp_trip,
  output logic por_q,
  output logic ovp_q,
  output logic drive_q
);
  logic on_prev;
  logic on_rise;

  assign on_rise = on_bit & ~on_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_prev <= 1'b0;
      por_q   <= 1'b1;
      ovp_q   <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      on_prev <= on_bit;
      if (stby_low)
        por_q <= 1'b1;
      else if (on_rise)
        por_q <= 1'b0;
      if (!on_bit)
        ovp_q <= 1'b0;
      else if (ovp_trip)
        ovp_q <= 1'b1;
      drive_q <= on_bit & ~por_q & ~ovp_q;
    end
  end

  // R8: a low standby supply always leaves the flag set
  p_stby_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stby_low |=> por_q);
  // R7: the flag only falls on an off-to-on step
  p_por_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (por_q && !(on_bit && !on_prev)) |=> por_q);
  // R9: the protection latch is held clear while off
  p_ovp_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !on_bit |=> !ovp_q);
  // R11: any fault removes the drives
  p_drive_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (por_q || ovp_q) |=> !drive_q);
endmodule

// File: rtl/ctl_bus_slave.sv
module ctl_bus_slave
  import ctl_bus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CHIP_ID     = 4'h5,
  parameter int                SYNC_STAGES = 2,
  parameter int                N_REGS      = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_clk,
  input  logic                    ser_en_n,
  input  logic                    ser_din,
  output logic                    ser_dout,
  output logic                    ser_doe,
  input  logic                    stby_low,
  input  logic                    ovp_trip,
  input  logic                    hlock,
  input  logic                    xfer_done,
  input  logic [MEAS_W-1:0]       tune_err,
  output logic                    pwm_en,
  output logic                    hdrv_en,
  output logic [N_REGS*VAL_W-1:0] ctl_regs
);
  logic    clk_rise, en_n_s, din_s;
  logic    wr_valid;
  reg_wr_t wr_data;
  logic    on_bit;
  logic    por_q, ovp_q, drive_q;
  status_t stat;

  assign stat = '{por: por_q, ovp: ovp_q, lock: hlock, xfer: xfer_done};

  ctl_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .ser_clk(ser_clk), .ser_en_n(ser_en_n), .ser_din(ser_din),
    .clk_rise(clk_rise), .en_n_s(en_n_s), .din_s(din_s)
  );

  ctl_bus_engine #(.CHIP_ID(CHIP_ID)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .clk_rise(clk_rise), .en_n_s(en_n_s), .din_s(din_s),
    .stat_in(stat), .meas_in(tune_err),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .dout(ser_dout), .doe(ser_doe)
  );

  ctl_regfile #(.N_REGS(N_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .regs_flat(ctl_regs), .on_bit(on_bit)
  );

  ctl_fault_guard u_guard (
    .clk(clk), .rst_n(rst_n),
    .on_bit(on_bit), .stby_low(stby_low), .ovp_trip(ovp_trip),
    .por_q(por_q), .ovp_q(ovp_q), .drive_q(drive_q)
  );

  assign pwm_en  = drive_q;
  assign hdrv_en = drive_q;
endmodule

// File: tb/sim_ctl_bus_slave.sv
module sim_ctl_bus_slave;
  localparam int HB = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_clk = 1'b0, ser_en_n = 1'b1, ser_din = 1'b0;
  logic         ser_dout, ser_doe;
  logic         stby_low = 1'b0, ovp_trip = 1'b0, hlock = 1'b0, xfer_done = 1'b0;
  logic [7:0]   tune_err = 8'h00;
  logic         pwm_en, hdrv_en;
  logic [223:0] ctl_regs;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #4 clk = ~clk;

  ctl_bus_slave u0 (
    .clk(clk), .rst_n(rst_n),
    .ser_clk(ser_clk), .ser_en_n(ser_en_n), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_doe(ser_doe),
    .stby_low(stby_low), .ovp_trip(ovp_trip), .hlock(hlock),
    .xfer_done(xfer_done), .tune_err(tune_err),
    .pwm_en(pwm_en), .hdrv_en(hdrv_en), .ctl_regs(ctl_regs)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int reg_of(input int idx);
    return int'(ctl_regs[idx*7 +: 7]);
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [3:0] a, input logic [4:0] s, input logic [6:0] v,
                      input int nbits, output logic [15:0] rd, output logic [15:0] oe);
    logic [15:0] w;
    w  = {a, s, v};
    rd = '0;
    oe = '0;
    @(negedge clk);
    ser_en_n = 1'b0;
    wait_cyc(HB);
    for (int i = 0; i < nbits; i++) begin
      ser_din = w[15-i];
      wait_cyc(HB);
      ser_clk = 1'b1;
      wait_cyc(HB);
      ser_clk = 1'b0;
    end
    if (nbits >= 16) begin
      for (int i = 0; i < 16; i++) begin
        wait_cyc(HB);
        rd[15-i] = ser_dout;
        oe[15-i] = ser_doe;
        ser_clk = 1'b1;
        wait_cyc(HB);
        ser_clk = 1'b0;
      end
    end
    wait_cyc(HB);
    ser_en_n = 1'b1;
    wait_cyc(2*HB);
  endtask

  task automatic put(input logic [4:0] s, input logic [6:0] v);
    logic [15:0] rd, oe;
    xfer(4'h5, s, v, 16, rd, oe);
  endtask

  task automatic probe_status(output logic [3:0] st);
    logic [15:0] rd, oe;
    xfer(4'h5, 5'd9, 7'h00, 16, rd, oe);
    st = rd[11:8];
  endtask

  task automatic t_reset;
    chk("R1 pwm_en", int'(pwm_en), 0);
    chk("R1 hdrv_en", int'(hdrv_en), 0);
    chk("R1 ser_doe", int'(ser_doe), 0);
    chk("R1 regs zero", int'(ctl_regs == '0), 1);
  endtask

  task automatic t_write_read;
    logic [15:0] rd, oe;
    hlock = 1'b1; xfer_done = 1'b0; tune_err = 8'hC3;
    xfer(4'h5, 5'd5, 7'h2A, 16, rd, oe);
    chk("R3 ack", int'(rd[15:12]), 'hA);
    chk("R3 doe all reply bits", int'(oe), 'hFFFF);
    chk("R1 R5 status S0 set S2 lock", int'(rd[11:8]), 'b1010);
    chk("R6 tune byte", int'(rd[7:0]), 'hC3);
    chk("R2 reg5 written", reg_of(5), 'h2A);
  endtask

  task automatic t_power_on;
    logic [15:0] rd, oe;
    put(5'd0, 7'h01);
    wait_cyc(8);
    chk("R11 pwm on", int'(pwm_en), 1);
    chk("R11 hdrv on", int'(hdrv_en), 1);
    hlock = 1'b0; xfer_done = 1'b1; tune_err = 8'h5A;
    xfer(4'h5, 5'd1, 7'h00, 16, rd, oe);
    chk("R5 R7 reply after power on", int'(rd), 'hA15A);
  endtask

  task automatic t_mismatch;
    logic [15:0] rd, oe;
    xfer(4'h3, 5'd5, 7'h11, 16, rd, oe);
    chk("R4 doe low", int'(oe), 0);
    chk("R4 reg5 unchanged", reg_of(5), 'h2A);
  endtask

  task automatic t_abort;
    logic [15:0] rd, oe;
    xfer(4'h5, 5'd7, 7'h55, 10, rd, oe);
    chk("R10 partial dropped", reg_of(7), 0);
    xfer(4'h5, 5'd7, 7'h55, 16, rd, oe);
    chk("R10 next frame ok", reg_of(7), 'h55);
    chk("R10 next frame ack", int'(oe), 'hFFFF);
  endtask

  task automatic t_supply_loss;
    logic [3:0] st;
    @(negedge clk); stby_low = 1'b1;
    wait_cyc(3);
    stby_low = 1'b0;
    wait_cyc(6);
    chk("R7 pwm off", int'(pwm_en), 0);
    chk("R7 hdrv off", int'(hdrv_en), 0);
    put(5'd0, 7'h01);
    wait_cyc(8);
    chk("R7 on again no clear", int'(pwm_en), 0);
    probe_status(st);
    chk("R7 S0 latched", int'(st), 'b1001);
    put(5'd0, 7'h00);
    put(5'd0, 7'h01);
    wait_cyc(8);
    chk("R7 off-on restarts", int'(pwm_en), 1);
  endtask

  task automatic t_on_while_low;
    put(5'd0, 7'h00);
    @(negedge clk); stby_low = 1'b1;
    put(5'd0, 7'h01);
    wait_cyc(8);
    chk("R8 stays off", int'(hdrv_en), 0);
    stby_low = 1'b0;
    wait_cyc(10);
    chk("R8 still off after release", int'(pwm_en), 0);
    put(5'd0, 7'h00);
    put(5'd0, 7'h01);
    wait_cyc(8);
    chk("R8 restart", int'(pwm_en), 1);
  endtask

  task automatic t_protection;
    logic [3:0] st;
    @(negedge clk); ovp_trip = 1'b1;
    wait_cyc(2);
    ovp_trip = 1'b0;
    wait_cyc(6);
    chk("R9 drives off", int'(pwm_en), 0);
    probe_status(st);
    chk("R9 S1 latched", int'(st), 'b0101);
    put(5'd0, 7'h01);
    wait_cyc(8);
    chk("R9 on again no clear", int'(hdrv_en), 0);
    put(5'd0, 7'h00);
    probe_status(st);
    chk("R9 cleared by off", int'(st), 'b0001);
    @(negedge clk); ovp_trip = 1'b1;
    wait_cyc(2);
    ovp_trip = 1'b0;
    probe_status(st);
    chk("R9 ignored while off", int'(st), 'b0001);
    put(5'd0, 7'h01);
    wait_cyc(8);
    chk("R9 R11 restart", int'(pwm_en), 1);
    chk("R11 both drives equal", int'(hdrv_en), 1);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_write_read();
    t_power_on();
    t_mismatch();
    t_abort();
    t_supply_loss();
    t_on_while_low();
    t_protection();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule